// File: doc/BRIEF.md
# Branch and Skip Next-PC Unit

This block resolves where the program counter goes after a control-flow instruction and how many cycles that instruction occupies. The decoder hands it the current word address, a four-bit operation code, a raw offset field, a status-bit selector, the status byte, a compare-equal or bit-test result, a flag saying whether the following instruction is a two-word one, the 16-bit Z pointer and the return address already popped by the stack logic. When the unit accepts an operation it registers the next PC, the cycle cost and a request to raise the global interrupt-enable flag.

A two-state machine sequences the work. In `ST_READY` the unit accepts an operation on `go`. If the cost is one cycle it stays in `ST_READY` (transition *accept-single*). Otherwise it moves to `ST_FLUSH` (transition *accept-multi*). There it holds `stall` high so the pipeline discards the prefetched word, counts down the remaining cycles and returns to `ST_READY` when the count runs out (transition *drain-done*). While it is in `ST_FLUSH` it ignores new operations.

Top module: `pcflow_unit`

## Requirements
- R1: After reset `ready` is 1, `stall` is 0, `pc_next` is 0, `cyc_cost` is 1 and `ie_set` is 0.
- R2: Relative jump (code 1) and relative call (code 3) give `pc_now` + sext(`k_off[11:0]`) + 1, modulo 2^PCW. Their cost is 2 cycles for the jump and 3 for the call.
- R3: Indirect jump (code 2) and indirect call (code 4) give the low PCW bits of `z_ptr`. Their cost is 2 cycles for the jump and 3 for the call.
- R4: Return (code 5) and return-from-interrupt (code 6) give `ret_pc` and cost 4 cycles. `ie_set` is 1 only after code 6 and 0 after every other accepted code.
- R5: Flag branches test `status[flag_idx]`. Code 7 is taken when the bit is 1 and code 8 when it is 0.
- R6: Signed branches use N = `status[2]` and V = `status[3]`. Code 9 is taken when N xor V is 0 and code 10 when it is 1.
- R7: Unsigned branches use C = `status[0]`. Code 11 is taken when C is 0 and code 12 when C is 1.
- R8: Skip (code 13), when `test_hit` is 1, gives `pc_now`+2 if `next_long` is 0 or `pc_now`+3 if it is 1, at a cost of 2 cycles. When `test_hit` is 0 it gives `pc_now`+1 at a cost of 1 cycle.
- R9: The sequential code 0 and the unused codes 14 and 15 give `pc_now`+1 at a cost of 1 cycle.
- R10: After an accepting edge, `stall` is high and `ready` is low for exactly `cyc_cost`-1 cycles.
- R11: `go` during `stall` is ignored: `pc_next`, `cyc_cost` and `ie_set` keep their values.
- R12: A taken branch (codes 7 to 12) gives `pc_now` + sext(`k_off[6:0]`) + 1 modulo 2^PCW at a cost of 2 cycles. `k_off[11:7]` is ignored. A branch that is not taken gives `pc_now`+1 at a cost of 1 cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| go | input | 1 | Operation valid, taken only when `ready` is 1 |
| op_code | input | 4 | Control-flow operation code |
| pc_now | input | PCW | Word address of the current instruction |
| k_off | input | 12 | Raw signed offset field |
| flag_idx | input | 3 | Status bit selected by flag branches |
| status | input | 8 | Status byte |
| test_hit | input | 1 | Compare-equal or bit-test outcome for skips |
| next_long | input | 1 | Following instruction is two words long |
| z_ptr | input | 16 | Pointer used by the indirect forms |
| ret_pc | input | PCW | Return address supplied by the stack logic |
| ready | output | 1 | Unit is in `ST_READY` |
| stall | output | 1 | Prefetched word must be flushed |
| pc_next | output | PCW | Resolved next PC |
| cyc_cost | output | 3 | Cycles taken by the accepted operation |
| ie_set | output | 1 | Request to raise the interrupt-enable flag |

## Verification
The bench builds the unit with PCW = 5, which shrinks the address space to 32 words. Every current PC, including the wrap from the top of the space to zero, is then swept under every one of the sixteen codes. Offsets are spread over both sign halves of the 12-bit and 7-bit fields. The status byte, selector, test result and instruction length are varied with them, so every branch condition is seen both taken and not taken.

// File: rtl/pcflow_pkg.sv
package pcflow_pkg;

    typedef enum logic [3:0] {
        FL_SEQ   = 4'd0,
        FL_JREL  = 4'd1,
        FL_JIND  = 4'd2,
        FL_CREL  = 4'd3,
        FL_CIND  = 4'd4,
        FL_RET   = 4'd5,
        FL_RETI  = 4'd6,
        FL_BFSET = 4'd7,
        FL_BFCLR = 4'd8,
        FL_BSGE  = 4'd9,
        FL_BSLT  = 4'd10,
        FL_BUHS  = 4'd11,
        FL_BULO  = 4'd12,
        FL_SKIP  = 4'd13,
        FL_RSV14 = 4'd14,
        FL_RSV15 = 4'd15
    } flow_op_e;

    typedef enum logic {
        ST_READY = 1'b0,
        ST_FLUSH = 1'b1
    } seq_state_e;

    localparam int SR_C  = 0;
    localparam int SR_N  = 2;
    localparam int SR_V  = 3;
    localparam int CYC_W = 3;
    localparam int OFF_W = 12;
    localparam int BR_W  = 7;

endpackage

// File: rtl/pcflow_cond.sv
module pcflow_cond
    import pcflow_pkg::*;
(
    input  flow_op_e   op,
    input  logic [7:0] status,
    input  logic [2:0] flag_idx,
    input  logic       test_hit,
    output logic       cond_true
);

    logic n_xor_v;
    assign n_xor_v = status[SR_N] ^ status[SR_V];

    always_comb begin
        unique case (op)
            FL_BFSET: cond_true = status[flag_idx];
            FL_BFCLR: cond_true = ~status[flag_idx];
            FL_BSGE:  cond_true = ~n_xor_v;
            FL_BSLT:  cond_true = n_xor_v;
            FL_BUHS:  cond_true = ~status[SR_C];
            FL_BULO:  cond_true = status[SR_C];
            FL_SKIP:  cond_true = test_hit;
            FL_SEQ, FL_JREL, FL_JIND, FL_CREL, FL_CIND,
            FL_RET, FL_RETI, FL_RSV14, FL_RSV15:
                      cond_true = 1'b0;
        endcase
    end

endmodule

// File: rtl/pcflow_target.sv
module pcflow_target
    import pcflow_pkg::*;
#(
    parameter int PCW = 10,
    parameter int ZW  = 16
) (
    input  flow_op_e                op,
    input  logic [PCW-1:0]          pc_now,
    input  logic [OFF_W-1:0]        k_off,
    input  logic [ZW-1:0]           z_ptr,
    input  logic [PCW-1:0]          ret_pc,
    input  logic                    cond_true,
    input  logic                    next_long,
    output logic [PCW-1:0]          target,
    output logic [CYC_W-1:0]        cost,
    output logic                    ie_req
);

    localparam int EXT_W = 32;

    logic [EXT_W-1:0] k_long_ext;
    logic [EXT_W-1:0] k_short_ext;
    logic [PCW-1:0]   pc_inc;
    logic [PCW-1:0]   pc_rel_long;
    logic [PCW-1:0]   pc_rel_short;
    logic [PCW-1:0]   pc_skip;

    assign k_long_ext   = {{(EXT_W-OFF_W){k_off[OFF_W-1]}}, k_off};
    assign k_short_ext  = {{(EXT_W-BR_W){k_off[BR_W-1]}}, k_off[BR_W-1:0]};
    assign pc_inc       = pc_now + PCW'(1);
    assign pc_rel_long  = pc_inc + k_long_ext[PCW-1:0];
    assign pc_rel_short = pc_inc + k_short_ext[PCW-1:0];
    assign pc_skip      = pc_now + (next_long ? PCW'(3) : PCW'(2));

    always_comb begin
        ie_req = 1'b0;
        unique case (op)
            FL_JREL: begin target = pc_rel_long;      cost = CYC_W'(2); end
            FL_CREL: begin target = pc_rel_long;      cost = CYC_W'(3); end
            FL_JIND: begin target = z_ptr[PCW-1:0];   cost = CYC_W'(2); end
            FL_CIND: begin target = z_ptr[PCW-1:0];   cost = CYC_W'(3); end
            FL_RET:  begin target = ret_pc;           cost = CYC_W'(4); end
            FL_RETI: begin
                target = ret_pc;
                cost   = CYC_W'(4);
                ie_req = 1'b1;
            end
            FL_BFSET, FL_BFCLR, FL_BSGE, FL_BSLT, FL_BUHS, FL_BULO: begin
                target = cond_true ? pc_rel_short : pc_inc;
                cost   = cond_true ? CYC_W'(2) : CYC_W'(1);
            end
            FL_SKIP: begin
                target = cond_true ? pc_skip : pc_inc;
                cost   = cond_true ? CYC_W'(2) : CYC_W'(1);
            end
            FL_SEQ, FL_RSV14, FL_RSV15: begin
                target = pc_inc;
                cost   = CYC_W'(1);
            end
        endcase
    end

    always_comb begin
        AST_COST_BOUND: assert (cost >= CYC_W'(1) && cost <= CYC_W'(4)); // R10
    end

endmodule

// File: rtl/pcflow_unit.sv
module pcflow_unit
    import pcflow_pkg::*;
#(
    parameter int PCW = 10,
    parameter int ZW  = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             go,
    input  logic [3:0]       op_code,
    input  logic [PCW-1:0]   pc_now,
    input  logic [11:0]      k_off,
    input  logic [2:0]       flag_idx,
    input  logic [7:0]       status,
    input  logic             test_hit,
    input  logic             next_long,
    input  logic [ZW-1:0]    z_ptr,
    input  logic [PCW-1:0]   ret_pc,
    output logic             ready,
    output logic             stall,
    output logic [PCW-1:0]   pc_next,
    output logic [2:0]       cyc_cost,
    output logic             ie_set
);

    flow_op_e          op;
    logic              cond_true;
    logic [PCW-1:0]    target;
    logic [CYC_W-1:0]  cost;
    logic              ie_req;
    logic              accept;

    seq_state_e        state_q, state_nx;
    logic [CYC_W-1:0]  remain_q, remain_nx;

    assign op = flow_op_e'(op_code);

    pcflow_cond u_cond (
        .op        (op),
        .status    (status),
        .flag_idx  (flag_idx),
        .test_hit  (test_hit),
        .cond_true (cond_true)
    );

    pcflow_target #(.PCW(PCW), .ZW(ZW)) u_target (
        .op        (op),
        .pc_now    (pc_now),
        .k_off     (k_off),
        .z_ptr     (z_ptr),
        .ret_pc    (ret_pc),
        .cond_true (cond_true),
        .next_long (next_long),
        .target    (target),
        .cost      (cost),
        .ie_req    (ie_req)
    );

    assign accept = go && (state_q == ST_READY);

    always_comb begin
        state_nx  = state_q;
        remain_nx = remain_q;
        unique case (state_q)
            ST_READY: begin
                if (accept && cost > CYC_W'(1)) begin
                    state_nx  = ST_FLUSH;
                    remain_nx = cost - CYC_W'(1);
                end
            end
            ST_FLUSH: begin
                remain_nx = remain_q - CYC_W'(1);
                if (remain_q == CYC_W'(1)) begin
                    state_nx = ST_READY;
                end
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q  <= ST_READY;
            remain_q <= '0;
        end else begin
            state_q  <= state_nx;
            remain_q <= remain_nx;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pc_next  <= '0;
            cyc_cost <= 3'd1;
            ie_set   <= 1'b0;
        end else if (accept) begin
            pc_next  <= target;
            cyc_cost <= cost;
            ie_set   <= ie_req;
        end
    end

    assign ready = (state_q == ST_READY);
    assign stall = (state_q == ST_FLUSH);

    AST_HOLD_IN_FLUSH: assert property (@(posedge clk) disable iff (!rst_n)
        stall |=> $stable(pc_next) && $stable(cyc_cost) && $stable(ie_set)); // R11

    AST_FLUSH_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
        stall && remain_q == CYC_W'(1) |=> ready); // R10

    AST_SINGLE_NO_STALL: assert property (@(posedge clk) disable iff (!rst_n)
        accept && cost == CYC_W'(1) |=> ready && !stall); // R10

    AST_SEQ_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        accept && op_code == 4'd0 |=> pc_next == $past(pc_now) + PCW'(1) && cyc_cost == 3'd1); // R9

    AST_IE_RETI_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        accept && op_code != 4'd6 |=> !ie_set); // R4

    AST_SKIP_COST: assert property (@(posedge clk) disable iff (!rst_n)
        accept && op_code == 4'd13 |=> cyc_cost == ($past(test_hit) ? 3'd2 : 3'd1)); // R8

endmodule

// File: tb/pcflow_unit_bench.sv
module pcflow_unit_bench;

    localparam int PCW  = 5;
    localparam int MASK = (1 << PCW) - 1;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             go = 1'b0;
    logic [3:0]       op_code = '0;
    logic [PCW-1:0]   pc_now = '0;
    logic [11:0]      k_off = '0;
    logic [2:0]       flag_idx = '0;
    logic [7:0]       status = '0;
    logic             test_hit = 1'b0;
    logic             next_long = 1'b0;
    logic [15:0]      z_ptr = '0;
    logic [PCW-1:0]   ret_pc = '0;
    logic             ready, stall, ie_set;
    logic [PCW-1:0]   pc_next;
    logic [2:0]       cyc_cost;

    int checks = 0;
    int fails  = 0;
    int ticks  = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    pcflow_unit #(.PCW(PCW), .ZW(16)) u_pcflow_unit (
        .clk(clk), .rst_n(rst_n), .go(go), .op_code(op_code), .pc_now(pc_now),
        .k_off(k_off), .flag_idx(flag_idx), .status(status), .test_hit(test_hit),
        .next_long(next_long), .z_ptr(z_ptr), .ret_pc(ret_pc), .ready(ready),
        .stall(stall), .pc_next(pc_next), .cyc_cost(cyc_cost), .ie_set(ie_set)
    );

    task automatic report;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    always @(posedge clk) begin
        ticks++;
        if (ticks > 150000 && !done) begin
            fails++;
            $display("FAIL watchdog: run did not complete (actual ticks %0d, expected fewer)", ticks);
            report();
        end
    end

    function automatic string req_of(int op);
        case (op)
            1, 3:                 return "R2";
            2, 4:                 return "R3";
            5, 6:                 return "R4";
            7, 8:                 return "R5";
            9, 10:                return "R6";
            11, 12:               return "R7";
            13:                   return "R8";
            default:              return "R9";
        endcase
    endfunction

    task automatic model(input int op, input int pc, input int k, input int sel,
                         input int sr, input int hit, input int lng, input int z,
                         input int stk, output int epc, output int ecyc, output int eie);
        int k12, k7, c, nv, taken;
        k12 = (k >= 2048) ? k - 4096 : k;
        k7  = k & 127;
        k7  = (k7 >= 64) ? k7 - 128 : k7;
        c   = sr & 1;
        nv  = ((sr >> 2) ^ (sr >> 3)) & 1;
        eie = 0;
        taken = 0;
        epc = (pc + 1) & MASK;
        ecyc = 1;
        case (op)
            1: begin epc = (pc + k12 + 1) & MASK; ecyc = 2; end
            3: begin epc = (pc + k12 + 1) & MASK; ecyc = 3; end
            2: begin epc = z & MASK; ecyc = 2; end
            4: begin epc = z & MASK; ecyc = 3; end
            5: begin epc = stk & MASK; ecyc = 4; end
            6: begin epc = stk & MASK; ecyc = 4; eie = 1; end
            7:  taken = (sr >> sel) & 1;
            8:  taken = ((sr >> sel) & 1) ^ 1;
            9:  taken = nv ^ 1;
            10: taken = nv;
            11: taken = c ^ 1;
            12: taken = c;
            13: if (hit != 0) begin epc = (pc + (lng != 0 ? 3 : 2)) & MASK; ecyc = 2; end
            default: ;
        endcase
        if (op >= 7 && op <= 12 && taken != 0) begin
            epc = (pc + k7 + 1) & MASK;
            ecyc = 2;
        end
    endtask

    task automatic issue(input int op, input int pc, input int k, input int sel,
                         input int sr, input int hit, input int lng, input int z,
                         input int stk, input bit inject, input string tag);
        int epc, ecyc, eie, nst;
        model(op, pc, k, sel, sr, hit, lng, z, stk, epc, ecyc, eie);
        @(negedge clk);
        op_code = 4'(op); pc_now = PCW'(pc); k_off = 12'(k); flag_idx = 3'(sel);
        status = 8'(sr); test_hit = hit[0]; next_long = lng[0];
        z_ptr = 16'(z); ret_pc = PCW'(stk); go = 1'b1;
        @(negedge clk);
        go = 1'b0;
        nst = 0;
        while (stall) begin
            if (inject && nst == 0) begin
                op_code = 4'd1; pc_now = PCW'(pc + 7); k_off = 12'd3; go = 1'b1;
            end else begin
                go = 1'b0;
            end
            nst++;
            @(negedge clk);
        end
        go = 1'b0;
        checks++;
        if (int'(pc_next) != epc || int'(cyc_cost) != ecyc || int'(ie_set) != eie
            || nst != ecyc - 1 || !ready) begin
            fails++;
            $display("FAIL %s R10: op %0d pc %0d k %0d -> actual pc %0d cyc %0d ie %0d stall %0d, expected pc %0d cyc %0d ie %0d stall %0d",
                     tag, op, pc, k, pc_next, cyc_cost, ie_set, nst, epc, ecyc, eie, ecyc - 1);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        checks++;
        if (!(ready && !stall && pc_next == '0 && cyc_cost == 3'd1 && !ie_set)) begin
            fails++;
            $display("FAIL R1 reset: actual rdy %0b stall %0b pc %0d cyc %0d ie %0b, expected 1 0 0 1 0",
                     ready, stall, pc_next, cyc_cost, ie_set);
        end
        rst_n = 1'b1;

        // R2 wrap at the top of the address space, and a negative 12-bit offset
        issue(1, 31, 0, 0, 0, 0, 0, 0, 0, 0, "R2");
        issue(3, 2, 4095, 0, 0, 0, 0, 0, 0, 0, "R2");
        // R3 high bits of Z are dropped
        issue(2, 0, 0, 0, 0, 0, 0, 16'hFFE3, 0, 0, "R3");
        // R4 return-from-interrupt raises ie, a following return clears it
        issue(6, 4, 0, 0, 0, 0, 0, 0, 17, 0, "R4");
        issue(5, 4, 0, 0, 0, 0, 0, 0, 9, 0, "R4");
        // R5 flag branches on the top status bit
        issue(7, 10, 5, 7, 8'h80, 0, 0, 0, 0, 0, "R5");
        issue(8, 10, 5, 7, 8'h80, 0, 0, 0, 0, 0, "R5");
        // R6 N=1 V=1 means greater-or-equal
        issue(9, 6, 3, 0, 8'h0C, 0, 0, 0, 0, 0, "R6");
        issue(10, 6, 3, 0, 8'h04, 0, 0, 0, 0, 0, "R6");
        // R7 carry clear and set
        issue(11, 6, 2, 0, 8'h00, 0, 0, 0, 0, 0, "R7");
        issue(12, 6, 2, 0, 8'h00, 0, 0, 0, 0, 0, "R7");
        // R8 long skip wrapping past the top
        issue(13, 30, 0, 0, 0, 1, 1, 0, 0, 0, "R8");
        issue(13, 30, 0, 0, 0, 1, 0, 0, 0, 0, "R8");
        // R12 upper offset bits ignored, bit 6 is the sign
        issue(12, 8, 12'hF80 | 64, 0, 1, 0, 0, 0, 0, 0, "R12");
        issue(12, 8, 12'h07F, 0, 1, 0, 0, 0, 0, 0, "R12");
        // R11 a second request during the flush is dropped
        issue(3, 3, 5, 0, 0, 0, 0, 0, 0, 1, "R11");
        issue(6, 3, 0, 0, 0, 0, 0, 0, 22, 1, "R11");

        // near-exhaustive sweep over every code and PC
        for (int op = 0; op < 16; op++) begin
            for (int pc = 0; pc <= MASK; pc++) begin
                for (int ki = 0; ki < 17; ki++) begin
                    issue(op, pc, (ki * 255 + op * 7) & 4095, (pc + ki) & 7,
                          (pc * 37 + ki * 11 + op) & 255, ki & 1, (ki >> 1) & 1,
                          (pc * 613 + ki * 5) & 16'hFFFF, (pc * 7 + ki) & MASK,
                          0, req_of(op));
                end
            end
        end

        done = 1'b1;
        report();
    end

endmodule